// File: doc/BRIEF.md
# Two-Way Processor Mailbox Queue

This block lets two processors, called side A and side B, pass 32-bit words to each other through a shared mailbox. Each side owns a 16-word transmit queue. That same queue is the other side's receive queue, so a word pushed by A is popped by B in arrival order, and the reverse also holds. Each side reaches the mailbox over a small register port. A write with select 0 updates the side's 16-bit control word. A write with select 1 sends a word. A read with select 0 returns the control word. A read with select 2 pops a received word. Read data appears combinationally in the same cycle as the read strobe.

The control word shows the state of both queues as seen from that side. It also holds three software settings: an enable, a send-empty interrupt enable and a receive-not-empty interrupt enable. It carries a sticky error flag, which is set when a side sends into a full queue or pops an empty one. A clear command empties the side's own transmit queue. Each side has two interrupt outputs, send-empty and receive-not-empty. Each interrupt is a one-cycle pulse, either on a queue event or on a control write that arms the interrupt while its condition already holds. Both sides share one clock.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, both interrupt outputs on each side are low, and each side's control word reads 0x0101.
- R2: Words sent by one side are popped by the other side in first-in first-out order. Each direction holds up to 16 words. A receive read returns the head word on the same cycle as the read strobe.
- R3: A send while the local transmit queue holds 16 words sets control bit 14 (error) and changes neither the queue's contents nor its order.
- R4: A receive while the incoming queue is empty returns zero and sets control bit 14.
- R5: While a side's control bit 15 (enable) is 0, a send from that side is ignored and a receive on that side returns zero. Neither changes any queue or the error flag.
- R6: In each control word, bit 0 is "own transmit queue empty", bit 1 is "own transmit queue holds 16", bit 8 is "incoming queue empty" and bit 9 is "incoming queue holds 16". Each bit tracks the occupancy after every send, pop and clear.
- R7: A control write with bit 14 set clears the error flag. A control write with bit 14 clear leaves the flag as it was.
- R8: A control write with bit 3 set empties the writer's transmit queue. Bit 3 always reads as 0.
- R9: When a pop empties a queue while the sender's control bit 2 is set, the sender's send-empty interrupt pulses high for one cycle, starting the cycle after the pop.
- R10: When a word is accepted into a side's incoming queue while that side's control bit 10 is set, that side's receive-not-empty interrupt pulses for one cycle, starting the cycle after the send.
- R11: A control write that sets bit 2 pulses send-empty on the next cycle if the writer's transmit queue is empty after the write. A control write that sets bit 10 pulses receive-not-empty on the next cycle if the incoming queue is non-empty after the write.
- R12: Select code 0 addresses the control word, 1 the send port and 2 the receive port. Control bits 2, 10 and 15 read back as written. Bits 4 to 7 and 11 to 13 always read 0, and reads return zero unless read-enable is high with select 0 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Active-low synchronous reset |
| aWe | input | 1 | Side A write strobe |
| aRe | input | 1 | Side A read strobe |
| aSel | input | 2 | Side A register select (0 control, 1 send, 2 receive) |
| aWData | input | 32 | Side A write data |
| aRData | output | 32 | Side A read data, combinational |
| aIrqSendEmpty | output | 1 | Side A send-empty interrupt pulse |
| aIrqRecvNotEmpty | output | 1 | Side A receive-not-empty interrupt pulse |
| bWe | input | 1 | Side B write strobe |
| bRe | input | 1 | Side B read strobe |
| bSel | input | 2 | Side B register select (0 control, 1 send, 2 receive) |
| bWData | input | 32 | Side B write data |
| bRData | output | 32 | Side B read data, combinational |
| bIrqSendEmpty | output | 1 | Side B send-empty interrupt pulse |
| bIrqRecvNotEmpty | output | 1 | Side B receive-not-empty interrupt pulse |

## Verification
The assertions assume that each strobe stands for one access per cycle. A write with select 1 counts as a single send, and a pop takes effect only when read-enable is paired with select 2. With this assumption, a queue's occupancy can move by at most one per cycle unless a clear is issued. The bench drives at most one operation per side in each cycle and changes inputs only at the falling edge, so each access is sampled exactly once. It also runs both sides at the same moment, including a send into a queue while the far side pops it, which is the case where the pre-cycle occupancy decides acceptance.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } qStrobe_t;

  typedef struct packed {
    logic en;
    logic errAck;
    logic rneIe;
    logic seIe;
    logic clr;
  } ctrlFields_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SEND = 2'd1;
  localparam logic [1:0] SEL_RECV = 2'd2;

  localparam int CTRL_W    = 16;
  localparam int B_TXEMPTY = 0;
  localparam int B_TXFULL  = 1;
  localparam int B_SEIE    = 2;
  localparam int B_CLR     = 3;
  localparam int B_RXEMPTY = 8;
  localparam int B_RXFULL  = 9;
  localparam int B_RNEIE   = 10;
  localparam int B_ERR     = 14;
  localparam int B_EN      = 15;
endpackage

// File: rtl/ipc_queue.sv
module ipc_queue
  import ipc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strb,
  input  logic [WIDTH-1:0] wData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] countNext,
  output logic             drained
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] headPtr, tailPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    countNext = count;
    if (strb.clear) countNext = '0;
    else if (strb.push && !strb.pop) countNext = count + CNT_W'(1);
    else if (!strb.push && strb.pop) countNext = count - CNT_W'(1);
  end

  assign drained  = strb.pop && !strb.push && (count == CNT_W'(1));
  assign headData = mem[headPtr];

  always_ff @(posedge clk) begin
    if (strb.push && !strb.clear) mem[tailPtr] <= wData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      count <= countNext;
      if (strb.clear) begin
        headPtr <= '0;
        tailPtr <= '0;
      end else begin
        if (strb.push) tailPtr <= bump(tailPtr);
        if (strb.pop)  headPtr <= bump(headPtr);
      end
    end
  end
endmodule

// File: rtl/ipc_side_ctrl.sv
module ipc_side_ctrl
  import ipc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic             re,
  input  logic [1:0]       sel,
  input  ctrlFields_t      wrFields,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] txCountNext,
  input  logic             txDrained,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxCountNext,
  input  logic             rxPushed,
  input  logic [WIDTH-1:0] rxHead,
  output logic             txPush,
  output logic             txClear,
  output logic             rxPop,
  output logic [WIDTH-1:0] rData,
  output logic             irqSendEmpty,
  output logic             irqRecvNotEmpty
);
  logic enable, errFlag, seIe, rneIe;
  logic isCtrlWr, isSend, isRecv, txFull, rxEmpty, setErr;
  logic [CTRL_W-1:0] ctrlWord;

  assign isCtrlWr = we && (sel == SEL_CTRL);
  assign isSend   = we && (sel == SEL_SEND) && enable;
  assign isRecv   = re && (sel == SEL_RECV) && enable;
  assign txFull   = (txCount == CNT_W'(DEPTH));
  assign rxEmpty  = (rxCount == '0);

  assign txPush  = isSend && !txFull;
  assign rxPop   = isRecv && !rxEmpty;
  assign txClear = isCtrlWr && wrFields.clr;
  assign setErr  = (isSend && txFull) || (isRecv && rxEmpty);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable          <= 1'b0;
      errFlag         <= 1'b0;
      seIe            <= 1'b0;
      rneIe           <= 1'b0;
      irqSendEmpty    <= 1'b0;
      irqRecvNotEmpty <= 1'b0;
    end else begin
      errFlag <= setErr || (errFlag && !(isCtrlWr && wrFields.errAck));
      if (isCtrlWr) begin
        enable <= wrFields.en;
        seIe   <= wrFields.seIe;
        rneIe  <= wrFields.rneIe;
      end
      irqSendEmpty    <= (txDrained && seIe) ||
                         (isCtrlWr && wrFields.seIe && (txCountNext == '0));
      irqRecvNotEmpty <= (rxPushed && rneIe) ||
                         (isCtrlWr && wrFields.rneIe && (rxCountNext != '0));
    end
  end

  always_comb begin
    ctrlWord            = '0;
    ctrlWord[B_TXEMPTY] = (txCount == '0);
    ctrlWord[B_TXFULL]  = txFull;
    ctrlWord[B_SEIE]    = seIe;
    ctrlWord[B_RXEMPTY] = rxEmpty;
    ctrlWord[B_RXFULL]  = (rxCount == CNT_W'(DEPTH));
    ctrlWord[B_RNEIE]   = rneIe;
    ctrlWord[B_ERR]     = errFlag;
    ctrlWord[B_EN]      = enable;
  end

  always_comb begin
    rData = '0;
    if (re && (sel == SEL_CTRL)) rData = WIDTH'(ctrlWord);
    else if (rxPop)              rData = rxHead;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aWe,
  input  logic             aRe,
  input  logic [1:0]       aSel,
  input  logic [WIDTH-1:0] aWData,
  output logic [WIDTH-1:0] aRData,
  output logic             aIrqSendEmpty,
  output logic             aIrqRecvNotEmpty,
  input  logic             bWe,
  input  logic             bRe,
  input  logic [1:0]       bSel,
  input  logic [WIDTH-1:0] bWData,
  output logic [WIDTH-1:0] bRData,
  output logic             bIrqSendEmpty,
  output logic             bIrqRecvNotEmpty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  qStrobe_t qAB, qBA;
  ctrlFields_t aFields, bFields;
  logic [WIDTH-1:0] abHead, baHead;
  logic [CNT_W-1:0] abCount, abCountNext, baCount, baCountNext;
  logic abDrained, baDrained;
  logic aTxPush, aTxClear, aRxPop, bTxPush, bTxClear, bRxPop;

  assign aFields = '{en: aWData[B_EN], errAck: aWData[B_ERR], rneIe: aWData[B_RNEIE],
                     seIe: aWData[B_SEIE], clr: aWData[B_CLR]};
  assign bFields = '{en: bWData[B_EN], errAck: bWData[B_ERR], rneIe: bWData[B_RNEIE],
                     seIe: bWData[B_SEIE], clr: bWData[B_CLR]};

  assign qAB = '{push: aTxPush, pop: bRxPop, clear: aTxClear};
  assign qBA = '{push: bTxPush, pop: aRxPop, clear: bTxClear};

  ipc_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_qAB (
    .clk(clk), .rstN(rstN), .strb(qAB), .wData(aWData), .headData(abHead),
    .count(abCount), .countNext(abCountNext), .drained(abDrained)
  );

  ipc_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_qBA (
    .clk(clk), .rstN(rstN), .strb(qBA), .wData(bWData), .headData(baHead),
    .count(baCount), .countNext(baCountNext), .drained(baDrained)
  );

  ipc_side_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrlA (
    .clk(clk), .rstN(rstN), .we(aWe), .re(aRe), .sel(aSel), .wrFields(aFields),
    .txCount(abCount), .txCountNext(abCountNext), .txDrained(abDrained),
    .rxCount(baCount), .rxCountNext(baCountNext), .rxPushed(qBA.push), .rxHead(baHead),
    .txPush(aTxPush), .txClear(aTxClear), .rxPop(aRxPop), .rData(aRData),
    .irqSendEmpty(aIrqSendEmpty), .irqRecvNotEmpty(aIrqRecvNotEmpty)
  );

  ipc_side_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ctrlB (
    .clk(clk), .rstN(rstN), .we(bWe), .re(bRe), .sel(bSel), .wrFields(bFields),
    .txCount(baCount), .txCountNext(baCountNext), .txDrained(baDrained),
    .rxCount(abCount), .rxCountNext(abCountNext), .rxPushed(qAB.push), .rxHead(abHead),
    .txPush(bTxPush), .txClear(bTxClear), .rxPop(bRxPop), .rData(bRData),
    .irqSendEmpty(bIrqSendEmpty), .irqRecvNotEmpty(bIrqRecvNotEmpty)
  );
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
  import ipc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             aWe,
  input logic             aRe,
  input logic [1:0]       aSel,
  input logic             aClrBit,
  input logic [WIDTH-1:0] aRData,
  input logic             bRe,
  input logic [1:0]       bSel,
  input logic [CNT_W-1:0] abCount,
  input logic [CNT_W-1:0] baCount
);
  logic bPopReq;
  assign bPopReq = bRe && (bSel == SEL_RECV);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    abCount <= CNT_W'(DEPTH));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(aWe && (aSel == SEL_CTRL) && aClrBit) |=>
      (abCount == $past(abCount)) || (abCount == $past(abCount) + CNT_W'(1)) ||
      (abCount + CNT_W'(1) == $past(abCount)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!aWe && !bPopReq) |=> $stable(abCount));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (aWe && (aSel == SEL_SEND) && (abCount == CNT_W'(DEPTH)) && !bPopReq) |=>
      (abCount == CNT_W'(DEPTH)));

  p_empty_recv_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (aRe && (aSel == SEL_RECV) && (baCount == '0)) |-> (aRData == '0));

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    (aWe && (aSel == SEL_CTRL) && aClrBit) |=> (abCount == '0));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .aWe(aWe), .aRe(aRe), .aSel(aSel), .aClrBit(aWData[3]),
  .aRData(aRData), .bRe(bRe), .bSel(bSel), .abCount(abCount), .baCount(baCount)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  logic clk, rstN;
  logic aWe, aRe, bWe, bRe;
  logic [1:0] aSel, bSel;
  logic [31:0] aWData, bWData, aRData, bRData;
  logic aIrqSe, aIrqRne, bIrqSe, bIrqRne;

  ipc_mailbox u_dut (
    .clk(clk), .rstN(rstN),
    .aWe(aWe), .aRe(aRe), .aSel(aSel), .aWData(aWData), .aRData(aRData),
    .aIrqSendEmpty(aIrqSe), .aIrqRecvNotEmpty(aIrqRne),
    .bWe(bWe), .bRe(bRe), .bSel(bSel), .bWData(bWData), .bRData(bRData),
    .bIrqSendEmpty(bIrqSe), .bIrqRecvNotEmpty(bIrqRne)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // reference model
  logic [31:0] qa[$];  // A to B
  logic [31:0] qb[$];  // B to A
  bit enA, errA, seA, rneA, enB, errB, seB, rneB;
  bit xSeA, xRneA, xSeB, xRneB;

  function automatic logic [31:0] ctrlOf(bit en, bit er, bit rne, bit se, int tx, int rx);
    logic [31:0] w = 32'h0;
    w[15] = en; w[14] = er; w[10] = rne; w[9] = (rx == 16); w[8] = (rx == 0);
    w[2] = se; w[1] = (tx == 16); w[0] = (tx == 0);
    return w;
  endfunction

  function automatic logic [31:0] expRd(bit re, logic [1:0] sel, bit en, bit er, bit rne,
                                        bit se, int tx, int rx, logic [31:0] head);
    if (re && sel == 2'd0) return ctrlOf(en, er, rne, se, tx, rx);
    if (re && sel == 2'd2 && en && rx > 0) return head;
    return 32'h0;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [31:0] ha, hb;
    ha = (qb.size() > 0) ? qb[0] : 32'h0;
    hb = (qa.size() > 0) ? qa[0] : 32'h0;
    chk("aRData", aRData, expRd(aRe, aSel, enA, errA, rneA, seA, qa.size(), qb.size(), ha));
    chk("bRData", bRData, expRd(bRe, bSel, enB, errB, rneB, seB, qb.size(), qa.size(), hb));
    chk("aIrqSe", 32'(aIrqSe), 32'(xSeA));
    chk("aIrqRne", 32'(aIrqRne), 32'(xRneA));
    chk("bIrqSe", 32'(bIrqSe), 32'(xSeB));
    chk("bIrqRne", 32'(bIrqRne), 32'(xRneB));
  endtask

  task automatic modelStep();
    int cab = qa.size();
    int cba = qb.size();
    bit aCw = aWe && aSel == 2'd0;
    bit bCw = bWe && bSel == 2'd0;
    bit aSnd = aWe && aSel == 2'd1 && enA;
    bit bSnd = bWe && bSel == 2'd1 && enB;
    bit aRcv = aRe && aSel == 2'd2 && enA;
    bit bRcv = bRe && bSel == 2'd2 && enB;
    bit pushA = aSnd && cab < 16;
    bit pushB = bSnd && cba < 16;
    bit popA = aRcv && cba > 0;
    bit popB = bRcv && cab > 0;
    bit eA = (aSnd && cab == 16) || (aRcv && cba == 0);
    bit eB = (bSnd && cba == 16) || (bRcv && cab == 0);
    bit clrA = aCw && aWData[3];
    bit clrB = bCw && bWData[3];
    bit drainAB = popB && !pushA && cab == 1;
    bit drainBA = popA && !pushB && cba == 1;
    int nab, nba;
    if (clrA) qa.delete();
    else begin
      if (popB) void'(qa.pop_front());
      if (pushA) qa.push_back(aWData);
    end
    if (clrB) qb.delete();
    else begin
      if (popA) void'(qb.pop_front());
      if (pushB) qb.push_back(bWData);
    end
    nab = qa.size();
    nba = qb.size();
    xSeA  = (drainAB && seA) || (aCw && aWData[2] && nab == 0);
    xRneA = (pushB && rneA) || (aCw && aWData[10] && nba != 0);
    xSeB  = (drainBA && seB) || (bCw && bWData[2] && nba == 0);
    xRneB = (pushA && rneB) || (bCw && bWData[10] && nab != 0);
    errA = eA || (errA && !(aCw && aWData[14]));
    errB = eB || (errB && !(bCw && bWData[14]));
    if (aCw) begin enA = aWData[15]; seA = aWData[2]; rneA = aWData[10]; end
    if (bCw) begin enB = bWData[15]; seB = bWData[2]; rneB = bWData[10]; end
  endtask

  // called just after a falling edge with inputs already set
  task automatic cycle();
    #5;
    compareAll();
    modelStep();
    @(negedge clk);
  endtask

  task automatic setA(bit we, bit re, logic [1:0] sel, logic [31:0] d);
    aWe = we; aRe = re; aSel = sel; aWData = d;
  endtask
  task automatic setB(bit we, bit re, logic [1:0] sel, logic [31:0] d);
    bWe = we; bRe = re; bSel = sel; bWData = d;
  endtask
  task automatic idleBoth();
    setA(0, 0, 2'd0, 32'h0); setB(0, 0, 2'd0, 32'h0);
  endtask

  initial begin
    rstN = 1'b0;
    idleBoth();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    qa.delete(); qb.delete();
    {enA, errA, seA, rneA, enB, errB, seB, rneB} = '0;
    {xSeA, xRneA, xSeB, xRneB} = '0;

    // R1: reset state, control words read 0x0101
    curReq = "R1";
    setA(0, 1, 2'd0, 0); setB(0, 1, 2'd0, 0); cycle();
    idleBoth(); cycle();

    // R5: disabled side ignores send and returns zero on receive
    curReq = "R5";
    setA(1, 0, 2'd1, 32'hDEAD0001); setB(0, 1, 2'd2, 0); cycle();
    setA(0, 1, 2'd0, 0); setB(0, 1, 2'd0, 0); cycle();

    // R11: enabling with interrupt enables while tx empty arms send-empty
    curReq = "R11";
    setA(1, 0, 2'd0, 32'h8404); setB(1, 0, 2'd0, 32'h8404); cycle();
    idleBoth(); cycle();

    // R12: readback of written bits, unused bits zero
    curReq = "R12";
    setA(0, 1, 2'd0, 0); setB(0, 1, 2'd3, 0); cycle();

    // R2 / R10 / R6: fill A to B queue with 16 words
    curReq = "R10";
    for (int i = 0; i < 16; i++) begin
      setA(1, 0, 2'd1, 32'hA0000000 + i); setB(0, 1, 2'd0, 0); cycle();
    end
    curReq = "R6";
    setA(0, 1, 2'd0, 0); setB(0, 1, 2'd0, 0); cycle();

    // R3: send into full queue
    curReq = "R3";
    setA(1, 0, 2'd1, 32'hBAD0BAD0); setB(0, 0, 2'd0, 0); cycle();
    setA(0, 1, 2'd0, 0); idleBoth(); setA(0, 1, 2'd0, 0); cycle();

    // R7: write with bit 14 clear keeps error, with bit 14 set clears it
    curReq = "R7";
    setA(1, 0, 2'd0, 32'h8400); cycle();
    setA(0, 1, 2'd0, 0); cycle();
    setA(1, 0, 2'd0, 32'hC404); cycle();
    setA(0, 1, 2'd0, 0); cycle();

    // R2 / R9: B drains all words in order, send-empty pulses at A
    curReq = "R2";
    for (int i = 0; i < 16; i++) begin
      if (i == 15) curReq = "R9";
      setA(0, 0, 2'd0, 0); setB(0, 1, 2'd2, 0); cycle();
    end
    idleBoth(); cycle();

    // R4: receive on empty queue
    curReq = "R4";
    setB(0, 1, 2'd2, 0); cycle();
    setB(0, 1, 2'd0, 0); cycle();
    setB(1, 0, 2'd0, 32'hC404); cycle();

    // R2: simultaneous send and pop in both directions
    curReq = "R2";
    setA(1, 0, 2'd1, 32'h11111111); setB(1, 0, 2'd1, 32'h22222222); cycle();
    for (int i = 0; i < 6; i++) begin
      if (i % 2 == 0) begin setA(1, 0, 2'd1, 32'h33330000 + i); setB(0, 1, 2'd2, 0); end
      else begin setA(0, 1, 2'd2, 0); setB(1, 0, 2'd1, 32'h44440000 + i); end
      cycle();
    end

    // R8: clear own transmit queue, bit 3 reads zero
    curReq = "R8";
    setA(1, 0, 2'd0, 32'h840C); setB(0, 0, 2'd0, 0); cycle();
    setA(0, 1, 2'd0, 0); setB(0, 1, 2'd0, 0); cycle();
    setB(0, 1, 2'd2, 0); cycle();

    // R11: arm receive-not-empty while incoming queue has data
    curReq = "R11";
    setA(1, 0, 2'd0, 32'h8000); setB(1, 0, 2'd0, 32'h8000); cycle();
    setA(0, 0, 2'd0, 0); setB(1, 0, 2'd1, 32'h55555555); cycle();
    setA(1, 0, 2'd0, 32'h8400); setB(0, 0, 2'd0, 0); cycle();
    idleBoth(); cycle();

    // R5: disabled side with data waiting returns zero and keeps data
    curReq = "R5";
    setA(1, 0, 2'd0, 32'h0000); cycle();
    setA(0, 1, 2'd2, 0); cycle();
    setA(1, 0, 2'd1, 32'h66666666); cycle();
    setA(0, 1, 2'd0, 0); setB(0, 1, 2'd0, 0); cycle();

    // mixed traffic on both sides
    curReq = "R2";
    for (int i = 0; i < 3000; i++) begin
      int ra = $urandom_range(0, 9);
      int rb = $urandom_range(0, 9);
      logic [31:0] cfg;
      cfg = 32'h8000 | ($urandom & 32'h4404) | (($urandom_range(0, 15) == 0) ? 32'h8 : 32'h0);
      if (ra < 4) setA(1, 0, 2'd1, $urandom);
      else if (ra < 7) setA(0, 1, 2'd2, 0);
      else if (ra < 8) setA(0, 1, 2'd0, 0);
      else if (ra < 9) setA(1, 0, 2'd0, cfg);
      else setA(0, 0, 2'd0, 0);
      cfg = 32'h8000 | ($urandom & 32'h4404) | (($urandom_range(0, 15) == 0) ? 32'h8 : 32'h0);
      if (rb < 3) setB(1, 0, 2'd1, $urandom);
      else if (rb < 7) setB(0, 1, 2'd2, 0);
      else if (rb < 8) setB(0, 1, 2'd0, 0);
      else if (rb < 9) setB(1, 0, 2'd0, cfg);
      else setB(0, 0, 2'd0, 0);
      cycle();
    end
    idleBoth(); cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule